// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a real address by walking a chain of translation tables held in memory. On a start pulse it picks one of three address-space designations according to the requested mode. The designation's type field sets which level the walk begins at: first, second or third region table, or the segment table. The block then reads one 8-byte entry per level until it reaches a page entry or a large segment frame.

Each table read goes out as a single outstanding request. The request is held until memory answers with a valid strobe and the entry data. A walk ends with a one-cycle `done` pulse that carries the real address and write permission, or with a one-cycle `fault` pulse that carries a fault code and an exception identification word. While translation is disabled, the address passes through unchanged. A new walk can begin only after the previous walk has ended with one of these two pulses.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `done`, `fault` and `mem_req` are low.
- R2: With `xlat_en` low, a start produces `done` on the next cycle with `real_addr` equal to `va` and `wr_ok` high, and makes no memory read.
- R3: `asc_mode` selects the designation: 2'b00 and 2'b01 take `desc_pri`, 2'b10 takes `desc_sec` and 2'b11 takes `desc_home`. The mode bits reported in an identification word are 2'b00 for 2'b00 and 2'b01, and equal `asc_mode` otherwise.
- R4: The designation type is held in bits 3:2: 0 is segment, 1 is third region, 2 is second region and 3 is first region. The origin is held in bits 63:12. A type-0 designation requires `va[63:31]` to be zero, type 1 requires `va[63:42]` to be zero and type 2 requires `va[63:53]` to be zero. A violation gives fault code 2 and no memory read.
- R5: Each read address is the table origin plus a byte offset. The offset is (va>>50)&0x3FF8 at the first region level, (va>>39)&0x3FF8 at the second, (va>>28)&0x3FF8 at the third, (va>>17)&0x3FF8 at the segment level and (va>>9)&0x7F8 at the page level. `mem_req` stays high and `mem_addr` stays stable until `mem_vld`, and every address is 8-byte aligned.
- R6: A region or segment entry with bit 5 set gives fault code 0.
- R7: A region entry's bits 3:2 must equal the type of the table it points to (level below minus one in the R4 encoding). A mismatch gives fault code 2. A region entry's next origin is its bits 63:12.
- R8: A page entry with bit 10 set gives fault code 1.
- R9: A segment entry's page table origin is its bits 63:11. A valid page entry yields `real_addr` = {entry[63:12], va[11:0]}. Bit 9 set in the segment or page entry clears `wr_ok`.
- R10: When a segment entry has bit 10 set and `big_frame_en` is high, the walk stops there with `real_addr` = {entry[63:20], va[19:0]}. When `big_frame_en` is low, bit 10 is ignored and the page level is read.
- R11: A write (`is_write` high) that resolves without write permission gives fault code 3 with `wr_ok` low. The identification word is {va[63:12], 12'b0} OR'd with the mode bits and with 4.
- R12: For fault codes 0, 1 and 2, the identification word is {va[63:12], 12'b0} OR'd with the mode bits, and bit 2 is clear.
- R13: `done` and `fault` are one-cycle pulses that never coincide. A start raised while a walk is in progress is ignored, together with the address presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a translation (accepted when idle) |
| va | input | 64 | Virtual address |
| is_write | input | 1 | Access is a write |
| asc_mode | input | 2 | Address-space mode |
| desc_pri | input | 64 | Primary space designation |
| desc_sec | input | 64 | Secondary space designation |
| desc_home | input | 64 | Home space designation |
| big_frame_en | input | 1 | Allow 1 MiB segment frames |
| xlat_en | input | 1 | Translation enable |
| mem_req | output | 1 | Table entry read request |
| mem_addr | output | 64 | Table entry address |
| mem_vld | input | 1 | Read data valid |
| mem_data | input | 64 | Table entry read data |
| done | output | 1 | Translation finished pulse |
| fault | output | 1 | Fault pulse |
| fault_code | output | 2 | 0 segment, 1 page, 2 specification, 3 protection |
| fault_teid | output | 64 | Translation-exception identification |
| real_addr | output | 64 | Resulting real address |
| wr_ok | output | 1 | Write permitted |

## Verification
The last entry of a walk and the permission check both resolve on the same clock edge. That edge must give either a completion or a protection fault, never both. The bench drives writes whose final page or segment entry is read-only through several modes. Its reference model expects a single fault pulse with bit 2 set and the mode bits in the identification word, and no `done`. A second collision is a start raised, with a different address, while a read is outstanding. The bench judges it by requiring that the finished walk match the original address and read sequence exactly.

// File: rtl/xlat_walker.sv
module xlat_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] va,
  input  logic        is_write,
  input  logic [1:0]  asc_mode,
  input  logic [63:0] desc_pri,
  input  logic [63:0] desc_sec,
  input  logic [63:0] desc_home,
  input  logic        big_frame_en,
  input  logic        xlat_en,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  input  logic        mem_vld,
  input  logic [63:0] mem_data,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_code,
  output logic [63:0] fault_teid,
  output logic [63:0] real_addr,
  output logic        wr_ok
);
  localparam logic [1:0] F_SEG = 2'd0, F_PAGE = 2'd1, F_SPEC = 2'd2, F_PROT = 2'd3;

  logic        busy, wr_q, ro_q;
  logic [2:0]  lvl;
  logic [1:0]  mb_q, mb_in;
  logic [63:0] org, va_q, desc, offs, e;
  logic        range_bad;
  logic        s_flt, s_fin, s_ro;
  logic [1:0]  s_code;
  logic [63:0] s_real, s_org;

  assign desc  = (asc_mode == 2'b10) ? desc_sec : (asc_mode == 2'b11) ? desc_home : desc_pri;
  assign mb_in = (asc_mode == 2'b01) ? 2'b00 : asc_mode;
  assign e     = mem_data;
  assign mem_req  = busy;
  assign mem_addr = org + offs;

  logic unused_bits;
  assign unused_bits = ^{e[8:6], e[4], e[1:0], desc[11:4], desc[1:0]};

  always_comb begin
    case (desc[3:2])
      2'd0:    range_bad = |va[63:31];
      2'd1:    range_bad = |va[63:42];
      2'd2:    range_bad = |va[63:53];
      default: range_bad = 1'b0;
    endcase
  end

  always_comb begin
    case (lvl)
      3'd4:    offs = (va_q >> 50) & 64'h3FF8;
      3'd3:    offs = (va_q >> 39) & 64'h3FF8;
      3'd2:    offs = (va_q >> 28) & 64'h3FF8;
      3'd1:    offs = (va_q >> 17) & 64'h3FF8;
      default: offs = (va_q >> 9)  & 64'h07F8;
    endcase
  end

  always_comb begin
    s_flt  = 1'b0;
    s_fin  = 1'b0;
    s_code = F_SEG;
    s_ro   = ro_q;
    s_real = 64'd0;
    s_org  = {e[63:12], 12'd0};
    if (lvl >= 3'd2) begin
      if (e[5]) s_flt = 1'b1;
      else if (e[3:2] != 2'(lvl - 3'd2)) begin
        s_flt  = 1'b1;
        s_code = F_SPEC;
      end
    end else if (lvl == 3'd1) begin
      s_ro = e[9];
      if (e[5]) s_flt = 1'b1;
      else if (e[10] && big_frame_en) begin
        s_fin  = 1'b1;
        s_real = {e[63:20], va_q[19:0]};
      end else s_org = {e[63:11], 11'd0};
    end else begin
      if (e[10]) begin
        s_flt  = 1'b1;
        s_code = F_PAGE;
      end else begin
        s_fin  = 1'b1;
        s_ro   = ro_q | e[9];
        s_real = {e[63:12], va_q[11:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; lvl <= 3'd0; org <= '0; va_q <= '0; wr_q <= 1'b0; ro_q <= 1'b0;
      mb_q <= 2'd0; done <= 1'b0; fault <= 1'b0; fault_code <= 2'd0;
      fault_teid <= '0; real_addr <= '0; wr_ok <= 1'b0;
    end else begin
      done  <= 1'b0;
      fault <= 1'b0;
      if (!busy) begin
        if (start) begin
          va_q <= va;
          wr_q <= is_write;
          mb_q <= mb_in;
          ro_q <= 1'b0;
          if (!xlat_en) begin
            real_addr <= va;
            wr_ok     <= 1'b1;
            done      <= 1'b1;
          end else if (range_bad) begin
            fault      <= 1'b1;
            fault_code <= F_SPEC;
            fault_teid <= {va[63:12], 10'd0, mb_in};
          end else begin
            busy <= 1'b1;
            lvl  <= {1'b0, desc[3:2]} + 3'd1;
            org  <= {desc[63:12], 12'd0};
          end
        end
      end else if (mem_vld) begin
        ro_q <= s_ro;
        org  <= s_org;
        lvl  <= lvl - 3'd1;
        if (s_flt) begin
          busy       <= 1'b0;
          fault      <= 1'b1;
          fault_code <= s_code;
          fault_teid <= {va_q[63:12], 10'd0, mb_q};
        end else if (s_fin) begin
          busy      <= 1'b0;
          real_addr <= s_real;
          wr_ok     <= !s_ro;
          if (wr_q && s_ro) begin
            fault      <= 1'b1;
            fault_code <= F_PROT;
            fault_teid <= {va_q[63:12], 9'd0, 1'b1, mb_q};
          end else done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_vld,
  input logic [63:0] mem_addr,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code,
  input logic        teid_b2,
  input logic        wr_ok
);
  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault)); // R13
  AST_END_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (done || fault) |-> !mem_req); // R13
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_vld) |=> (mem_req && $stable(mem_addr))); // R5
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> (mem_addr[2:0] == 3'd0)); // R5
  AST_PROT_TEID: assert property (@(posedge clk) disable iff (!rst_n) (fault && fault_code == 2'd3) |-> (teid_b2 && !wr_ok)); // R11
  AST_OTHER_TEID: assert property (@(posedge clk) disable iff (!rst_n) (fault && fault_code != 2'd3) |-> !teid_b2); // R12
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_vld(mem_vld), .mem_addr(mem_addr),
  .done(done), .fault(fault), .fault_code(fault_code), .teid_b2(fault_teid[2]), .wr_ok(wr_ok)
);

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_write = 1'b0, big = 1'b0, en = 1'b0;
  logic [63:0] va = '0, dpri = '0, dsec = '0, dhome = '0, mem_data = '0;
  logic [1:0] md = 2'd0;
  logic mem_vld = 1'b0;
  logic mem_req, done, fault, wr_ok;
  logic [63:0] mem_addr, fault_teid, real_addr;
  logic [1:0] fault_code;

  int nchk = 0, nfail = 0, wcnt = 0;
  bit exp_busy = 0;
  logic [63:0] mem [longint unsigned];
  logic [63:0] seen [$];
  logic [63:0] e_addrs [$];
  bit e_fault, e_wr;
  logic [1:0] e_code;
  logic [63:0] e_teid, e_real;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .is_write(is_write), .asc_mode(md),
    .desc_pri(dpri), .desc_sec(dsec), .desc_home(dhome), .big_frame_en(big), .xlat_en(en),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_vld(mem_vld), .mem_data(mem_data),
    .done(done), .fault(fault), .fault_code(fault_code), .fault_teid(fault_teid),
    .real_addr(real_addr), .wr_ok(wr_ok)
  );

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  function automatic logic [63:0] rdm(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] off(input int l, input logic [63:0] v);
    case (l)
      4: return (v >> 50) & 64'h3FF8;
      3: return (v >> 39) & 64'h3FF8;
      2: return (v >> 28) & 64'h3FF8;
      1: return (v >> 17) & 64'h3FF8;
      default: return (v >> 9) & 64'h07F8;
    endcase
  endfunction

  // memory model: answers LAT cycles after a request appears
  always @(negedge clk) begin
    if (mem_vld) begin
      mem_vld <= 1'b0;
      wcnt <= 0;
    end else if (mem_req) begin
      if (wcnt == LAT) begin
        mem_vld  <= 1'b1;
        mem_data <= rdm(mem_addr);
        seen.push_back(mem_addr);
      end else wcnt <= wcnt + 1;
    end
  end

  // per-cycle comparison against reference state
  always @(negedge clk) begin
    if (rst_n) begin
      nchk++;
      if (!exp_busy && mem_req) begin
        nfail++;
        $display("FAIL R13 idle request actual=%b expected=0", mem_req);
      end
      nchk++;
      if (done && fault) begin
        nfail++;
        $display("FAIL R13 done/fault overlap actual=11 expected=not both");
      end
    end
  end

  task automatic set_fault(input logic [1:0] c, input logic [63:0] v, input logic [1:0] mb, input bit p);
    e_fault = 1;
    e_code  = c;
    e_teid  = {v[63:12], 12'd0} | {62'd0, mb} | (p ? 64'd4 : 64'd0);
  endtask

  task automatic model(input logic [63:0] v, input bit w, input logic [1:0] m);
    logic [63:0] d, ent, org;
    logic [1:0] mb;
    int l;
    bit ro;
    e_addrs.delete();
    e_fault = 0; ro = 0; e_wr = 1;
    mb = (m == 2'b01) ? 2'b00 : m;
    if (!en) begin e_real = v; return; end
    d = (m == 2'b10) ? dsec : (m == 2'b11) ? dhome : dpri;
    l = int'(d[3:2]) + 1;
    if ((l == 1 && v[63:31] != 0) || (l == 2 && v[63:42] != 0) || (l == 3 && v[63:53] != 0)) begin
      set_fault(2'd2, v, mb, 0); return;
    end
    org = {d[63:12], 12'd0};
    while (1) begin
      e_addrs.push_back(org + off(l, v));
      ent = rdm(org + off(l, v));
      if (l >= 2) begin
        if (ent[5]) begin set_fault(2'd0, v, mb, 0); return; end
        if (int'(ent[3:2]) != l - 2) begin set_fault(2'd2, v, mb, 0); return; end
        org = {ent[63:12], 12'd0};
        l--;
      end else if (l == 1) begin
        if (ent[5]) begin set_fault(2'd0, v, mb, 0); return; end
        ro = ent[9];
        if (ent[10] && big) begin e_real = {ent[63:20], v[19:0]}; break; end
        org = {ent[63:11], 11'd0};
        l = 0;
      end else begin
        if (ent[10]) begin set_fault(2'd1, v, mb, 0); return; end
        ro = ro | ent[9];
        e_real = {ent[63:12], v[11:0]};
        break;
      end
    end
    e_wr = !ro;
    if (w && ro) set_fault(2'd3, v, mb, 1);
  endtask

  task automatic chain(input logic [63:0] v, input int top, input logic [63:0] org0,
                       input bit fc, input bit sro, input bit pro, input bit sinv,
                       input bit pinv, input int bad_l, input int inv_l);
    logic [63:0] org, nxt, ent;
    org = org0;
    for (int l = top; l >= 0; l--) begin
      nxt = org + 64'h10_0000;
      if (l >= 2) begin
        ent = {nxt[63:12], 12'd0} | (64'(l - 2) << 2);
        if (bad_l == l) ent[3:2] = ent[3:2] ^ 2'b01;
        if (inv_l == l) ent[5] = 1'b1;
      end else if (l == 1) begin
        ent = {nxt[63:11], 11'd0};
        ent[10] = fc; ent[9] = sro; ent[5] = sinv;
      end else begin
        ent = 64'h0000_7654_3210_0000 + org0;
        ent[9] = pro; ent[10] = pinv;
      end
      mem[org + off(l, v)] = ent;
      org = nxt;
    end
  endtask

  task automatic run(input string tag, input logic [63:0] v, input bit w, input logic [1:0] m, input bit poke);
    int cyc;
    model(v, w, m);
    seen.delete();
    @(negedge clk);
    va = v; is_write = w; md = m; start = 1'b1; exp_busy = 1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 2000) begin
      if (poke && cyc == 3) begin start = 1'b1; va = ~v; end
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    exp_busy = 0;
    chk({tag, " R13 walk ended"}, 64'(cyc < 2000), 64'd1);
    chk({tag, " fault flag"}, 64'(fault), 64'(e_fault));
    chk({tag, " done flag"}, 64'(done), 64'(!e_fault));
    if (e_fault) begin
      chk({tag, " fault code"}, 64'(fault_code), 64'(e_code));
      chk({tag, " R12 teid"}, fault_teid, e_teid);
      if (e_code == 2'd3) chk({tag, " R11 wr_ok"}, 64'(wr_ok), 64'd0);
    end else begin
      chk({tag, " real_addr"}, real_addr, e_real);
      chk({tag, " R9 wr_ok"}, 64'(wr_ok), 64'(e_wr));
    end
    chk({tag, " R5 read count"}, 64'(seen.size()), 64'(e_addrs.size()));
    for (int i = 0; i < e_addrs.size() && i < seen.size(); i++)
      chk({tag, " R5 read addr"}, seen[i], e_addrs[i]);
    @(negedge clk);
    chk({tag, " R13 pulse width"}, 64'({done, fault}), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 done reset", 64'(done), 64'd0);
    chk("R1 fault reset", 64'(fault), 64'd0);
    chk("R1 mem_req reset", 64'(mem_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    en = 0;
    run("R2 disabled", 64'hDEAD_BEEF_0123_4567, 1, 2'b00, 0);

    en = 1;
    dpri  = 64'h1_0000_0000 | (64'd3 << 2);
    dsec  = 64'h2_0000_0000 | (64'd0 << 2);
    dhome = 64'h3_0000_0000 | (64'd1 << 2);
    chain(64'h1234_5678_9ABC_DEF0, 4, 64'h1_0000_0000, 0, 0, 0, 0, 0, -1, -1);
    run("R5 R9 primary full walk", 64'h1234_5678_9ABC_DEF0, 0, 2'b00, 0);
    run("R3 mode01 primary", 64'h1234_5678_9ABC_DEF0, 1, 2'b01, 0);
    run("R13 start ignored busy", 64'h1234_5678_9ABC_DEF0, 0, 2'b00, 1);

    chain(64'h0000_0000_5A5A_5123, 1, 64'h2_0000_0000, 0, 0, 0, 0, 0, -1, -1);
    run("R3 secondary segment write", 64'h0000_0000_5A5A_5123, 1, 2'b10, 0);

    chain(64'h0000_02AB_CDEF_1234, 2, 64'h3_0000_0000, 0, 0, 1, 0, 0, -1, -1);
    run("R9 home ro page read", 64'h0000_02AB_CDEF_1234, 0, 2'b11, 0);
    run("R11 home ro page write", 64'h0000_02AB_CDEF_1234, 1, 2'b11, 0);

    chain(64'h0000_0000_1357_9BDF, 1, 64'h2_0000_0000, 0, 1, 0, 0, 0, -1, -1);
    run("R11 seg ro write secondary", 64'h0000_0000_1357_9BDF, 1, 2'b10, 0);

    run("R4 segment range", 64'h0000_0000_8000_0000, 0, 2'b10, 0);
    run("R4 region3 range", 64'h0000_0400_0000_0000, 0, 2'b11, 0);
    dsec = 64'h4_0000_0000 | (64'd2 << 2);
    run("R4 region2 range", 64'h0020_0000_0000_0000, 0, 2'b10, 0);
    chain(64'h001F_0000_1234_5678, 3, 64'h4_0000_0000, 0, 0, 0, 0, 0, -1, -1);
    run("R5 region2 walk", 64'h001F_0000_1234_5678, 0, 2'b10, 0);

    chain(64'h0ABC_0000_0000_1000, 4, 64'h5_0000_0000, 0, 0, 0, 0, 0, -1, 3);
    dpri = 64'h5_0000_0000 | (64'd3 << 2);
    run("R6 region invalid", 64'h0ABC_0000_0000_1000, 0, 2'b00, 0);
    chain(64'h0ABC_0000_0000_2000, 4, 64'h5_0000_0000, 0, 0, 0, 1, 0, -1, -1);
    run("R6 segment invalid", 64'h0ABC_0000_0000_2000, 0, 2'b00, 0);
    chain(64'h0ABC_0000_0000_3000, 4, 64'h5_0000_0000, 0, 0, 0, 0, 0, 2, -1);
    run("R7 type mismatch", 64'h0ABC_0000_0000_3000, 0, 2'b00, 0);

    chain(64'h0000_0000_0765_4321, 1, 64'h4_8000_0000, 0, 0, 0, 0, 1, -1, -1);
    dsec = 64'h4_8000_0000;
    run("R8 page invalid", 64'h0000_0000_0765_4321, 0, 2'b10, 0);

    chain(64'h7777_0000_0ABC_DEF1, 4, 64'h6_0000_0000, 1, 1, 0, 0, 0, -1, -1);
    dpri = 64'h6_0000_0000 | (64'd3 << 2);
    big = 1;
    run("R10 large frame", 64'h7777_0000_0ABC_DEF1, 0, 2'b00, 0);
    run("R10 R11 large frame write", 64'h7777_0000_0ABC_DEF1, 1, 2'b00, 0);
    big = 0;
    run("R10 large disabled", 64'h7777_0000_0ABC_DEF1, 0, 2'b00, 0);

    summary();
    $finish;
  end
endmodule